// File: doc/BRIEF.md
# SPI Serial EEPROM Slave

This block is an SPI slave in front of a 512-byte storage array held in on-chip registers. It behaves like a small serial EEPROM. A host drives chip select, serial clock and serial data in, and reads serial data out. The data-out pin comes with an enable, so the pad can be left floating when the enable is low.

All three SPI inputs are synchronised into the system clock. Serial clock edges are then detected by oversampling, so the block works in SPI mode 0 and in mode 3.

Writes are protected in three ways:
- A write enable latch must be set in an earlier frame.
- A block-protect field selects a region of the array that is locked against writes.
- Write data is collected in a 16-byte page buffer and reaches the array only after chip select rises.

Programming is followed by a busy period of fixed length. During that period only the status read is answered.

Top module: `spiee_top`

## Requirements
- R1: A frame holding only opcode 0x06, closed by chip select rising on a byte boundary, sets the write enable latch (status bit 1). Any opcode sent after 0x06 in that same frame is ignored, so a write sent there leaves the array unchanged.
- R2: The write opcode is 0000_A010 and the read opcode is 0000_A011. Bit 3 (A) gives address bit 8, and the next byte gives address bits 7:0.
- R3: Each data byte of a write goes to the current address. Then only address bits 3:0 increment, wrapping inside the 16-byte page. A later byte for the same location replaces the earlier one.
- R4: The array changes only after chip select rises. From that point status bit 0 reads 1 for WRITE_CYCLES clock cycles.
- R5: The write enable latch clears when the busy period ends. Opcode 0x04, sent in its own frame, clears it as well.
- R6: Status bits 3:2 select the locked region: 00 none, 01 addresses 0x180 and up, 10 addresses 0x100 and up, 11 all. A write to a locked page programs nothing, does not start a busy period and leaves the latch set.
- R7: Opcode 0x01 followed by a data byte is accepted only while the latch is set. It updates status bits 7, 4, 3 and 2 after chip select rises, and starts a busy period. Status bits 6:5 always read 0.
- R8: Opcode 0x05 returns the status byte, repeated for every further byte of the frame. Read and status data leave MSB first. The output enable stays low during a whole write frame.
- R9: While busy, every opcode except 0x05 is ignored: writes, latch commands, and reads (whose output enable stays low).
- R10: A write frame closed in the middle of a byte, or closed before any complete data byte, programs nothing and leaves the latch unchanged.
- R11: A read continues through ascending addresses for as long as clocks arrive, wrapping from 0x1FF to 0x000.
- R12: Every command behaves the same whether the clock idles low (mode 0) or high (mode 3).
- R13: After reset the status reads 0x00, the output enable is low and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the SPI pins |
| rstN | input | 1 | Asynchronous reset, active low |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | SPI serial clock |
| si | input | 1 | Serial data from the host |
| so | output | 1 | Serial data to the host |
| soEn | output | 1 | Output enable for the data-out pad |

## Verification
Two events can fall in the same system clock cycle: the end of the busy period, which clears busy and the latch together, and the byte boundary of a status read, which loads the status byte into the output shifter.

The bench provokes this by holding one status-read frame open across the whole busy period. Every returned byte must then be either 0x03 or 0x00, and once 0x00 has appeared it must stay. A byte that shows the latch without busy, or busy without the latch, exposes a torn update.

Random page writes are run in both clock polarities and compared against a bench model of the array.

// File: rtl/spiee_pkg.sv
package spiee_pkg;
  localparam int ADDR_W = 9;
  localparam int DEPTH  = 1 << ADDR_W;

  localparam logic [7:0] OP_LATCH_ON  = 8'h06;
  localparam logic [7:0] OP_LATCH_OFF = 8'h04;
  localparam logic [7:0] OP_STAT_RD   = 8'h05;
  localparam logic [7:0] OP_STAT_WR   = 8'h01;
  localparam logic [2:0] OP_RD_TAIL   = 3'b011;
  localparam logic [2:0] OP_WR_TAIL   = 3'b010;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_LATCH_ON, CMD_LATCH_OFF, CMD_STAT_RD,
    CMD_STAT_WR, CMD_READ, CMD_WRITE, CMD_SKIP
  } cmd_e;

  typedef struct packed {
    logic addrLoad;
    logic bufWrite;
    logic bufClear;
    logic commit;
    logic txLoadMem;
    logic txLoadStat;
    logic txShift;
    logic rdAdvance;
  } dpStrobe_t;

  function automatic cmd_e decodeOp(input logic [7:0] op);
    if (op[7:4] != 4'h0)      return CMD_SKIP;
    if (op == OP_LATCH_ON)    return CMD_LATCH_ON;
    if (op == OP_LATCH_OFF)   return CMD_LATCH_OFF;
    if (op == OP_STAT_RD)     return CMD_STAT_RD;
    if (op == OP_STAT_WR)     return CMD_STAT_WR;
    if (op[2:0] == OP_RD_TAIL) return CMD_READ;
    if (op[2:0] == OP_WR_TAIL) return CMD_WRITE;
    return CMD_SKIP;
  endfunction

  // top two address bits against block-protect code
  function automatic logic isLocked(input logic [1:0] bp, input logic [1:0] top2);
    case (bp)
      2'b01:   return top2 == 2'b11;
      2'b10:   return top2[1];
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/spiee_sync.sv
module spiee_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < STAGES; k++) chain[k] <= INIT;
    end else begin
      chain[0] <= d;
      for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spiee_ctrl.sv
module spiee_ctrl
  import spiee_pkg::*;
#(
  parameter int WRITE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csS,
  input  logic       sckS,
  input  logic       siS,
  input  logic [1:0] addrTop,
  output dpStrobe_t  stb,
  output logic [7:0] rxByte,
  output logic       addrHi,
  output logic [7:0] statusByte,
  output logic       soEn
);
  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  logic             csPrev, sckPrev;
  logic [2:0]       bitCnt;
  logic [6:0]       rxSh;
  logic [1:0]       byteCnt;
  cmd_e             cmd, opCmd, decoded;
  logic             wel, busy;
  logic [1:0]       bp;
  logic             nv4, nv7;
  logic [CNT_W-1:0] busyCnt;
  logic             dataSeen, wrsrSeen;
  logic [3:0]       wrsrBits;
  logic             csRise, sckRise, sckFall, byteDone, frameOk;
  logic             startWrite, startStat;

  assign csRise   = csS & ~csPrev;
  assign sckRise  = sckS & ~sckPrev & ~csS;
  assign sckFall  = ~sckS & sckPrev & ~csS;
  assign byteDone = sckRise & (bitCnt == 3'd7);
  assign rxByte   = {rxSh, siS};
  assign frameOk  = csRise & (bitCnt == 3'd0);

  assign decoded = decodeOp(rxByte);
  always_comb begin
    opCmd = decoded;
    if (busy && decoded != CMD_STAT_RD) opCmd = CMD_SKIP;
    else if (!wel && (decoded == CMD_WRITE || decoded == CMD_STAT_WR)) opCmd = CMD_SKIP;
  end

  assign statusByte = {nv7, 2'b00, nv4, bp, wel, busy};
  assign startWrite = frameOk & (cmd == CMD_WRITE) & dataSeen & ~isLocked(bp, addrTop);
  assign startStat  = frameOk & (cmd == CMD_STAT_WR) & wrsrSeen;

  always_comb begin
    stb            = '0;
    stb.addrLoad   = byteDone & (byteCnt == 2'd1) & (cmd == CMD_WRITE || cmd == CMD_READ);
    stb.txLoadMem  = byteDone & (cmd == CMD_READ) & (byteCnt != 2'd0);
    stb.rdAdvance  = byteDone & (cmd == CMD_READ) & (byteCnt == 2'd2);
    stb.bufWrite   = byteDone & (cmd == CMD_WRITE) & (byteCnt == 2'd2);
    stb.bufClear   = byteDone & (byteCnt == 2'd0);
    stb.commit     = startWrite;
    stb.txLoadStat = byteDone & (((byteCnt == 2'd0) & (opCmd == CMD_STAT_RD)) |
                                 ((byteCnt != 2'd0) & (cmd == CMD_STAT_RD)));
    stb.txShift    = sckFall & (bitCnt != 3'd0);
  end

  assign soEn = ~csS & ((cmd == CMD_STAT_RD) | ((cmd == CMD_READ) & (byteCnt == 2'd2)));

  // frame tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sckPrev  <= 1'b0;
      bitCnt   <= '0;
      rxSh     <= '0;
      byteCnt  <= '0;
      cmd      <= CMD_NONE;
      addrHi   <= 1'b0;
      dataSeen <= 1'b0;
      wrsrSeen <= 1'b0;
      wrsrBits <= '0;
    end else begin
      csPrev  <= csS;
      sckPrev <= sckS;
      if (csS) begin
        bitCnt   <= '0;
        byteCnt  <= '0;
        cmd      <= CMD_NONE;
        dataSeen <= 1'b0;
        wrsrSeen <= 1'b0;
      end else if (sckRise) begin
        rxSh   <= rxByte[6:0];
        bitCnt <= bitCnt + 3'd1;
        if (byteDone) begin
          if (byteCnt != 2'd2) byteCnt <= byteCnt + 2'd1;
          if (byteCnt == 2'd0) begin
            cmd    <= opCmd;
            addrHi <= rxByte[3];
          end
          if (cmd == CMD_WRITE && byteCnt == 2'd2) dataSeen <= 1'b1;
          if (cmd == CMD_STAT_WR && byteCnt == 2'd1) begin
            wrsrSeen <= 1'b1;
            wrsrBits <= {rxByte[7], rxByte[4:2]};
          end
        end
      end
    end
  end

  // latch, status and busy timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel     <= 1'b0;
      busy    <= 1'b0;
      busyCnt <= '0;
      bp      <= '0;
      nv4     <= 1'b0;
      nv7     <= 1'b0;
    end else if (busy) begin
      if (busyCnt == '0) begin
        busy <= 1'b0;
        wel  <= 1'b0;
      end else begin
        busyCnt <= busyCnt - 1'b1;
      end
    end else if (frameOk) begin
      if (cmd == CMD_LATCH_ON)  wel <= 1'b1;
      if (cmd == CMD_LATCH_OFF) wel <= 1'b0;
      if (startWrite || startStat) begin
        busy    <= 1'b1;
        busyCnt <= CNT_W'(WRITE_CYCLES - 1);
      end
      if (startStat) begin
        nv7 <= wrsrBits[3];
        nv4 <= wrsrBits[2];
        bp  <= wrsrBits[1:0];
      end
    end
  end
endmodule

// File: rtl/spiee_datapath.sv
module spiee_datapath
  import spiee_pkg::*;
#(
  parameter int PAGE_W = 4,
  parameter logic [7:0] ERASED = 8'hFF
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  stb,
  input  logic [7:0] rxByte,
  input  logic       addrHi,
  input  logic [7:0] statusByte,
  output logic       txMsb,
  output logic [1:0] addrTop
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [7:0]        mem     [DEPTH];
  logic [7:0]        pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] bufValid;
  logic [ADDR_W-1:0] addr, nextAddr;
  logic [7:0]        tx;

  always_comb begin
    if (stb.addrLoad)       nextAddr = {addrHi, rxByte};
    else if (stb.rdAdvance) nextAddr = addr + 1'b1;
    else                    nextAddr = addr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (stb.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (bufValid[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pageBuf[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (stb.bufClear) begin
      bufValid <= '0;
    end else if (stb.bufWrite) begin
      pageBuf[addr[PAGE_W-1:0]]  <= rxByte;
      bufValid[addr[PAGE_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) addr <= '0;
    else if (stb.bufWrite)
      addr <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
    else addr <= nextAddr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              tx <= '0;
    else if (stb.txLoadMem) tx <= mem[nextAddr];
    else if (stb.txLoadStat) tx <= statusByte;
    else if (stb.txShift)   tx <= {tx[6:0], 1'b0};
  end

  assign txMsb   = tx[7];
  assign addrTop = addr[ADDR_W-1:ADDR_W-2];
endmodule

// File: rtl/spiee_top.sv
module spiee_top
  import spiee_pkg::*;
#(
  parameter int WRITE_CYCLES = 64,
  parameter int PAGE_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic soEn
);
  logic [2:0] pinSync;
  dpStrobe_t  stb;
  logic [7:0] rxByte, statusByte;
  logic       addrHi, txMsb;
  logic [1:0] addrTop;

  spiee_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) sync_i (
    .clk(clk), .rstN(rstN), .d({csN, sck, si}), .q(pinSync));

  spiee_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .csS(pinSync[2]), .sckS(pinSync[1]), .siS(pinSync[0]),
    .addrTop(addrTop), .stb(stb), .rxByte(rxByte), .addrHi(addrHi),
    .statusByte(statusByte), .soEn(soEn));

  spiee_datapath #(.PAGE_W(PAGE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rxByte(rxByte), .addrHi(addrHi),
    .statusByte(statusByte), .txMsb(txMsb), .addrTop(addrTop));

  assign so = soEn & txMsb;
endmodule

// File: rtl/spiee_checker.sv
module spiee_checker (
  input logic clk,
  input logic rstN,
  input logic soEn,
  input logic commit,
  input logic bufWrite,
  input logic busyBit,
  input logic latchBit
);
  assert_commit_needs_latch_R1: assert property (@(posedge clk) disable iff (!rstN)
    commit |-> latchBit && !busyBit);
  assert_busy_follows_commit_R4: assert property (@(posedge clk) disable iff (!rstN)
    commit |=> busyBit);
  assert_latch_drops_at_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyBit) |-> !latchBit);
  assert_quiet_during_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    bufWrite |-> !soEn);
  assert_busy_blocks_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    busyBit |-> !bufWrite && !commit);
endmodule

bind spiee_top spiee_checker chk_i (
  .clk(clk), .rstN(rstN), .soEn(soEn), .commit(stb.commit), .bufWrite(stb.bufWrite),
  .busyBit(statusByte[0]), .latchBit(statusByte[1]));

// File: tb/spiee_top_tb_top.sv
`timescale 1ns/1ps
module spiee_top_tb_top;
  localparam int BUSY = 1200;
  localparam int H = 4;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, soEn;
  int checks = 0, fails = 0;
  bit mode3 = 1'b0, sawSoEn = 1'b0;
  logic [7:0] model [512];
  logic [1:0] mBp = 2'b00;
  logic mWel = 1'b0, mN4 = 1'b0, mN7 = 1'b0;

  always #2.5 clk = ~clk;

  spiee_top #(.WRITE_CYCLES(BUSY)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so), .soEn(soEn));

  function automatic logic [7:0] expStat(input logic busyV);
    return {mN7, 2'b00, mN4, mBp, mWel, busyV};
  endfunction

  function automatic bit locked(input logic [1:0] b, input logic [8:0] a);
    case (b)
      2'b01:   return a >= 9'h180;
      2'b10:   return a >= 9'h100;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csLow();
    sck = mode3; tick(3); csN = 1'b0; tick(6);
  endtask

  task automatic csHigh();
    if (!mode3) sck = 1'b0;
    tick(H); csN = 1'b1; tick(8);
  endtask

  task automatic xfer(input logic [7:0] b, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0; si = b[i]; tick(H);
      r[i] = so;
      if (soEn) sawSoEn = 1'b1;
      sck = 1'b1; tick(H);
    end
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, d);
  endtask

  task automatic cmd1(input logic [7:0] op);
    csLow(); send(op); csHigh();
  endtask

  task automatic rdsr(output logic [7:0] s);
    csLow(); send(8'h05); xfer(8'h00, s); csHigh();
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int k = 0; k < 100; k++) begin
      rdsr(s);
      if (!s[0]) break;
    end
    mWel = 1'b0;
  endtask

  task automatic doWrite(input logic [8:0] a, input int n, input bit commitExp);
    logic [7:0] d;
    csLow(); send({4'b0000, a[8], 3'b010}); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send(d);
      if (commitExp) model[{a[8:4], 4'(a[3:0] + i)}] = d;
    end
    csHigh();
  endtask

  task automatic readChk(input logic [8:0] a, input int n, input string req);
    logic [7:0] r;
    csLow(); send({4'b0000, a[8], 3'b011}); send(a[7:0]);
    for (int i = 0; i < n; i++) begin
      xfer(8'h00, r);
      check(req, r, model[9'(a + i)]);
    end
    csHigh();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] s, r;
    bit seenIdle, prot;
    logic [8:0] a;
    logic [8:0] probe [3];
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) model[i] = 8'hFF;
    tick(5); rstN = 1'b1; tick(5);

    // R13 reset state
    check("R13 soEn", {7'd0, soEn}, 8'h00);
    rdsr(s); check("R13 status", s, 8'h00);
    readChk(9'h000, 2, "R13 erased");

    // R1 latch set by its own frame
    cmd1(8'h06); mWel = 1'b1;
    rdsr(s); check("R1 latch", s, expStat(1'b0));
    cmd1(8'h04); mWel = 1'b0;
    rdsr(s); check("R5 latch off", s, expStat(1'b0));
    csLow(); send(8'h06); send(8'h02); send(8'h10); send(8'hAA); csHigh();
    mWel = 1'b1;
    rdsr(s); check("R1 same-frame latch", s, expStat(1'b0));
    readChk(9'h010, 1, "R1 same-frame write ignored");

    // R10 aborted frames
    csLow(); send(8'h02); send(8'h20); send(8'h55);
    for (int i = 0; i < 3; i++) begin sck = 1'b0; si = 1'b1; tick(H); sck = 1'b1; tick(H); end
    csHigh();
    rdsr(s); check("R10 partial byte", s, expStat(1'b0));
    readChk(9'h020, 1, "R10 not programmed");
    csLow(); send(8'h02); send(8'h21); csHigh();
    rdsr(s); check("R10 no data", s, expStat(1'b0));

    // R4 R8 R9 write with A8 set, then commands during busy
    sawSoEn = 1'b0;
    doWrite(9'h1F3, 5, 1'b1);
    check("R8 soEn low in write", {7'd0, sawSoEn}, 8'h00);
    rdsr(s); check("R4 busy", s, expStat(1'b1));
    doWrite(9'h040, 1, 1'b0);
    cmd1(8'h04);
    rdsr(s); check("R9 latch cmd ignored", s, expStat(1'b1));
    sawSoEn = 1'b0;
    csLow(); send(8'h03); send(8'h00); send(8'h00); csHigh();
    check("R9 read ignored", {7'd0, sawSoEn}, 8'h00);
    waitIdle();
    rdsr(s); check("R5 latch cleared", s, expStat(1'b0));
    readChk(9'h1F0, 16, "R2 upper half");
    readChk(9'h040, 1, "R9 write ignored");

    // overlap: status frame held across end of busy
    cmd1(8'h06); mWel = 1'b1;
    doWrite(9'h0A0, 3, 1'b1);
    seenIdle = 1'b0;
    csLow(); send(8'h05);
    for (int k = 0; k < 40; k++) begin
      xfer(8'h00, s);
      check("R5 status coherent", s, (seenIdle || s == 8'h00) ? 8'h00 : 8'h03);
      if (s == 8'h00) seenIdle = 1'b1;
    end
    csHigh(); mWel = 1'b0;
    check("R4 busy ends", {7'd0, seenIdle}, 8'h01);
    readChk(9'h0A0, 3, "R4 programmed");

    // R3 R12 random page writes in both modes
    for (int it = 0; it < 14; it++) begin
      mode3 = 1'($urandom);
      a = 9'($urandom);
      cmd1(8'h06); mWel = 1'b1;
      doWrite(a, 1 + int'($urandom % 20), 1'b1);
      waitIdle();
      readChk({a[8:4], 4'h0}, 16, mode3 ? "R12 mode3 page" : "R3 page");
    end
    mode3 = 1'b0;

    // R7 status write
    cmd1(8'h06); mWel = 1'b1;
    csLow(); send(8'h01); send(8'hFF); csHigh();
    waitIdle(); mBp = 2'b11; mN4 = 1'b1; mN7 = 1'b1;
    rdsr(s); check("R7 writable bits", s, 8'h9C);

    // R6 protection ranges
    probe[0] = 9'h1F8; probe[1] = 9'h108; probe[2] = 9'h008;
    for (int b = 1; b < 4; b++) begin
      cmd1(8'h06); mWel = 1'b1;
      csLow(); send(8'h01); send(8'(b << 2) | 8'h63); csHigh();
      waitIdle(); mBp = 2'(b); mN4 = 1'b0; mN7 = 1'b0;
      rdsr(s); check("R7 masked bits", s, expStat(1'b0));
      for (int p = 0; p < 3; p++) begin
        prot = locked(mBp, probe[p]);
        cmd1(8'h06); mWel = 1'b1;
        doWrite(probe[p], 2, !prot);
        if (prot) begin
          rdsr(s); check("R6 locked rejected", s, expStat(1'b0));
          cmd1(8'h04); mWel = 1'b0;
        end else begin
          waitIdle();
        end
        readChk(probe[p], 2, "R6 content");
      end
    end
    csLow(); send(8'h01); send(8'h00); csHigh();
    rdsr(s); check("R7 needs latch", s, expStat(1'b0));
    cmd1(8'h06); mWel = 1'b1;
    csLow(); send(8'h01); send(8'h00); csHigh();
    waitIdle(); mBp = 2'b00;
    rdsr(s); check("R7 cleared", s, 8'h00);

    // R11 read wraps the array, R8 repeated status
    readChk(9'h1FE, 4, "R11 wrap");
    mode3 = 1'b1;
    csLow(); send(8'h05); xfer(8'h00, s); xfer(8'h00, r); csHigh();
    check("R8 status repeat", r, s);
    cmd1(8'h06); mWel = 1'b1;
    doWrite(9'h0C5, 4, 1'b1);
    waitIdle();
    readChk(9'h0C5, 4, "R12 mode3 write");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule